// File: doc/BRIEF.md
# Serial SRAM Host Controller

This block is the host-side engine for a byte-addressed serial SRAM on a four-wire SPI bus in mode 0. A core-side command port takes an operation code, a 16-bit start address and a byte count. The engine then runs the whole memory transaction inside one chip-select window: the opcode, the address bytes and the payload. Write payload bytes arrive over a valid/ready handshake, and if the next byte is late the serial clock waits. Read payload bytes leave as one-cycle strobes.

Coming out of reset, the engine pulses chip select low once with no clock, to put the memory into a known state. It then writes the status register to select sequential access with the hold function disabled. A size query reads the memory's density code and turns it into a byte count. The clear-all operation uses that count to fill the memory with zero bytes.

The serial clock period is `2*HALF_DIV` system clocks. `HALF_DIV` must be chosen so that the serial clock stays at or below 20 MHz.

Top module: `sram_spi_host`

## Requirements
- R1: Every bus byte is 8 bits, most significant bit first, in SPI mode 0. The memory samples `spi_mosi` on the rising edge of `spi_sclk`, and the engine samples `spi_miso` on that same rising edge.
- R2: The shortest `spi_sclk` period is exactly `2*HALF_DIV` system clock cycles.
- R3: During reset `spi_cs_n` is 1, `spi_sclk` is 0 and `busy` is 1. After reset there is one chip-select low pulse with no clock edges, followed by a window carrying exactly the bytes 0x01 and `CFG_VAL` (default 0x41).
- R4: A single write (op 1) sends 0x02, the address high byte, the address low byte and exactly one data byte, whatever `cmd_count` holds.
- R5: A read (op 3 single, op 4 burst) sends 0x03 and the two address bytes, then one 0x00 per result byte. Each result byte appears on `rd_data` with a one-cycle `rd_valid`, in bus order.
- R6: A burst write (op 2) or burst read (op 4) moves exactly `cmd_count` data bytes within a single chip-select window.
- R7: `wr_ready` is high while the engine waits for a write byte. Until `wr_valid` arrives, `spi_sclk` stays 0 and `spi_cs_n` stays 0.
- R8: A size query (op 6) sends 0x0E and then 0xFF. The byte returned during the 0xFF is the density code. Codes 0, 1, 2 and 3 set `mem_bytes` to 8192, 16384, 32768 and 65536. Any other code sets it to 0. `mem_bytes` is 0 after reset.
- R9: Clear-all (op 5) ignores `cmd_addr` and `cmd_count`. It sends 0x02, 0x00, 0x00 and then `mem_bytes` zero bytes in one window.
- R10: Op codes are 0 configure, 1 single write, 2 burst write, 3 single read, 4 burst read, 5 clear-all and 6 size query. A command is taken only when `busy` is 0 and the op is not 7. `busy` stays high from acceptance until the chip-select gap after the window has ended, and any command presented while busy is ignored.
- R11: `spi_sclk` is 0 whenever `spi_cs_n` is 1. Between two windows, `spi_cs_n` stays 1 for at least `2*HALF_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code (see R10) |
| cmd_addr | input | 16 | Start address |
| cmd_count | input | CNT_W | Byte count for bursts |
| busy | output | 1 | Engine is running a transaction |
| wr_valid | input | 1 | Write byte offered |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Engine takes a write byte |
| rd_valid | output | 1 | One-cycle strobe for a read byte |
| rd_data | output | 8 | Read byte |
| mem_bytes | output | CNT_W | Detected memory size in bytes |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The assertions assume two things. First, `wr_valid` is raised only while `wr_ready` is high and is held until the byte has been taken. Second, `spi_miso` changes only while `spi_sclk` is low, as a mode 0 memory behaves. The stimulus meets both assumptions. The write-data driver offers a byte only when it sees `wr_ready` at a falling system-clock edge, and withdraws it one cycle after the transfer. The bench's memory model updates its output bit only on falling `spi_sclk` edges. Commands are driven away from the active edge, and some of them are deliberately issued while the engine is busy.

// File: rtl/sram_spi_pkg.sv
// Shared types for the serial SRAM host controller.
package sram_spi_pkg;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned BYTE_W = 8;

    // Command codes seen on cmd_op; code 7 is never accepted.
    typedef enum logic [2:0] {
        OP_CFG  = 3'd0,
        OP_WR1  = 3'd1,
        OP_WRB  = 3'd2,
        OP_RD1  = 3'd3,
        OP_RDB  = 3'd4,
        OP_CLR  = 3'd5,
        OP_SIZE = 3'd6
    } sram_op_e;

    // Transaction sequencer states.
    typedef enum logic [2:0] {
        ST_BOOT_HI,
        ST_BOOT_LO,
        ST_GAP,
        ST_IDLE,
        ST_HDR,
        ST_HDR_WAIT,
        ST_PAY,
        ST_PAY_WAIT
    } seq_state_e;
endpackage

// File: rtl/sram_spi_shifter.sv
// Mode 0 byte shifter. It sends one byte most significant bit first and
// captures one byte on the rising serial clock edges.
// Assumes: start is pulsed only while active is low. The serial clock is
// low for HALF_DIV cycles and then high for HALF_DIV cycles per bit.
module sram_spi_shifter #(
    parameter int unsigned HALF_DIV = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       active,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int unsigned DIV_W = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
    localparam logic [DIV_W-1:0] HALF_LAST = DIV_W'(HALF_DIV - 1);

    logic [DIV_W-1:0] half_q;
    logic [2:0]       bit_q;
    logic [7:0]       tx_q;

    // Half-period timer, clock edges, shift and capture for one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q  <= '0;
            bit_q   <= '0;
            tx_q    <= '0;
            rx_byte <= '0;
            sclk    <= 1'b0;
            active  <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    tx_q   <= tx_byte;
                    half_q <= '0;
                    bit_q  <= '0;
                end
            end else if (half_q == HALF_LAST) begin
                half_q <= '0;
                if (!sclk) begin
                    sclk    <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    tx_q <= {tx_q[6:0], 1'b0};
                    if (bit_q == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                    end
                end
            end else begin
                half_q <= half_q + 1'b1;
            end
        end
    end

    assign mosi = tx_q[7];

    // R1: a byte ends on a falling edge, so the clock is low at completion
    // r1_done_low_chk
    assert property (@(posedge clk) disable iff (!rst_n) done |-> !sclk)
        else $error("r1_done_low_chk");
endmodule

// File: rtl/sram_size_decode.sv
// Density decoder. It turns the code returned by a size query into a byte
// count: codes 0 to 3 give 8 KiB shifted left by the code, any other
// code gives 0. Assumes OUT_W is at least 17.
module sram_size_decode #(
    parameter int unsigned OUT_W = 17
) (
    input  logic [7:0]       code,
    output logic [OUT_W-1:0] bytes
);
    localparam logic [OUT_W-1:0] BASE = OUT_W'(8192);

    // Map the code to a power-of-two size, or 0 when the code is unknown.
    always_comb begin
        if (code < 8'd4) bytes = BASE << code[1:0];
        else             bytes = '0;
    end
endmodule

// File: rtl/sram_spi_host.sv
// Serial SRAM host controller. It frames whole memory transactions (opcode,
// address, payload) inside one chip-select window, runs the boot pulse and
// configuration, and keeps the detected size.
// Assumes: wr_valid is held until it is taken; HALF_DIV >= 1; CNT_W >= 17.
module sram_spi_host
    import sram_spi_pkg::*;
#(
    parameter int unsigned HALF_DIV   = 7,
    parameter int unsigned CNT_W      = 17,
    parameter logic [7:0]  OPC_READ   = 8'h03,
    parameter logic [7:0]  OPC_WRITE  = 8'h02,
    parameter logic [7:0]  OPC_WRSR   = 8'h01,
    parameter logic [7:0]  OPC_MODEID = 8'h0E,
    parameter logic [7:0]  CFG_VAL    = 8'h41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic              busy,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    output logic              wr_ready,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic [CNT_W-1:0]  mem_bytes,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    localparam int unsigned GAP_CYC = 2 * HALF_DIV;
    localparam int unsigned TMR_W   = $clog2(GAP_CYC + 1);
    localparam logic [TMR_W-1:0] GAP_LAST  = TMR_W'(GAP_CYC - 1);
    localparam logic [TMR_W-1:0] HALF_LAST = TMR_W'(HALF_DIV - 1);

    seq_state_e        state_q;
    sram_op_e          op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem_q, acc_rem, dec_bytes;
    logic [1:0]        idx_q;
    logic [TMR_W-1:0]  tmr_q;
    logic              boot_q, accept, is_wr, is_rd, hdr_last;
    logic              sh_start, sh_active, sh_done;
    logic [7:0]        hdr_byte, pay_byte, sh_tx, sh_rx;

    // Classify the current operation and select the byte to send next.
    always_comb begin
        is_wr    = (op_q == OP_WR1) || (op_q == OP_WRB);
        is_rd    = (op_q == OP_RD1) || (op_q == OP_RDB);
        hdr_last = ((op_q == OP_CFG) || (op_q == OP_SIZE)) ? (idx_q == 2'd0)
                                                           : (idx_q == 2'd2);
        case (idx_q)
            2'd0: begin
                if (op_q == OP_CFG)       hdr_byte = OPC_WRSR;
                else if (op_q == OP_SIZE) hdr_byte = OPC_MODEID;
                else if (is_rd)           hdr_byte = OPC_READ;
                else                      hdr_byte = OPC_WRITE;
            end
            2'd1:    hdr_byte = addr_q[15:8];
            default: hdr_byte = addr_q[7:0];
        endcase
        if (is_wr)                pay_byte = wr_data;
        else if (op_q == OP_CFG)  pay_byte = CFG_VAL;
        else if (op_q == OP_SIZE) pay_byte = 8'hFF;
        else                      pay_byte = 8'h00;
        wr_ready = (state_q == ST_PAY) && is_wr && (rem_q != '0);
        sh_start = (state_q == ST_HDR) ||
                   ((state_q == ST_PAY) && (rem_q != '0) && (!is_wr || wr_valid));
        sh_tx    = (state_q == ST_HDR) ? hdr_byte : pay_byte;
        accept   = (state_q == ST_IDLE) && cmd_valid && (cmd_op != 3'd7);
        case (sram_op_e'(cmd_op))
            OP_CLR:  acc_rem = mem_bytes;
            OP_WRB,
            OP_RDB:  acc_rem = cmd_count;
            default: acc_rem = CNT_W'(1);
        endcase
    end

    // Sequencer: boot pulse, configuration, command framing and gaps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_BOOT_HI;
            op_q      <= OP_CFG;
            addr_q    <= '0;
            rem_q     <= '0;
            idx_q     <= '0;
            tmr_q     <= '0;
            boot_q    <= 1'b1;
            mem_bytes <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (state_q)
                ST_BOOT_HI: begin
                    if (tmr_q == GAP_LAST) begin
                        tmr_q   <= '0;
                        state_q <= ST_BOOT_LO;
                    end else tmr_q <= tmr_q + 1'b1;
                end
                ST_BOOT_LO: begin
                    if (tmr_q == HALF_LAST) begin
                        tmr_q   <= '0;
                        state_q <= ST_GAP;
                    end else tmr_q <= tmr_q + 1'b1;
                end
                ST_GAP: begin
                    if (tmr_q == GAP_LAST) begin
                        tmr_q <= '0;
                        if (boot_q) begin
                            boot_q  <= 1'b0;
                            op_q    <= OP_CFG;
                            rem_q   <= CNT_W'(1);
                            idx_q   <= '0;
                            state_q <= ST_HDR;
                        end else state_q <= ST_IDLE;
                    end else tmr_q <= tmr_q + 1'b1;
                end
                ST_IDLE: begin
                    if (accept) begin
                        op_q    <= sram_op_e'(cmd_op);
                        addr_q  <= (sram_op_e'(cmd_op) == OP_CLR) ? '0 : cmd_addr;
                        rem_q   <= acc_rem;
                        idx_q   <= '0;
                        state_q <= ST_HDR;
                    end
                end
                ST_HDR: state_q <= ST_HDR_WAIT;
                ST_HDR_WAIT: begin
                    if (sh_done) begin
                        if (hdr_last) state_q <= ST_PAY;
                        else begin
                            idx_q   <= idx_q + 2'd1;
                            state_q <= ST_HDR;
                        end
                    end
                end
                ST_PAY: begin
                    if (rem_q == '0)  state_q <= ST_GAP;
                    else if (sh_start) state_q <= ST_PAY_WAIT;
                end
                ST_PAY_WAIT: begin
                    if (sh_done) begin
                        rem_q   <= rem_q - 1'b1;
                        state_q <= ST_PAY;
                        if (is_rd) begin
                            rd_valid <= 1'b1;
                            rd_data  <= sh_rx;
                        end
                        if (op_q == OP_SIZE) mem_bytes <= dec_bytes;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign spi_cs_n = !((state_q == ST_BOOT_LO) || (state_q == ST_HDR) ||
                        (state_q == ST_HDR_WAIT) || (state_q == ST_PAY) ||
                        (state_q == ST_PAY_WAIT));

    sram_spi_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .active  (sh_active),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    sram_size_decode #(.OUT_W(CNT_W)) u_size (
        .code  (sh_rx),
        .bytes (dec_bytes)
    );

    // R11
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk) else $error("sclk_idle_chk");
    // R11
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> spi_cs_n) else $error("cs_gap_chk");
    // R7
    wr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && !wr_valid) |=> (!spi_sclk && !spi_cs_n)) else $error("wr_stall_chk");
    // R8
    size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_bytes)) else $error("size_code_chk");
    // R10
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy) else $error("busy_window_chk");
    // R1
    byte_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |-> !sh_active) else $error("byte_overlap_chk");
endmodule

// File: tb/sram_spi_host_test.sv
module sram_spi_host_test;
    localparam int HD = 1;
    localparam int CW = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [15:0] cmd_addr = '0;
    logic [CW-1:0] cmd_count = '0;
    logic busy, wr_ready, rd_valid, spi_sclk, spi_mosi, spi_cs_n;
    logic wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [CW-1:0] mem_bytes;
    logic spi_miso = 1'b0;

    always #2 clk = ~clk;

    sram_spi_host #(.HALF_DIV(HD), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_count(cmd_count), .busy(busy),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_bytes(mem_bytes),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural serial SRAM model ----------------
    logic [7:0] mem [int];
    logic [7:0] cur [$];
    logic [7:0] last [$];
    logic [7:0] in_sh = '0, out_sh = '0, opc = '0, status = '0, mode_code = '0;
    logic [15:0] saddr = '0;
    int bitc = 0, nby = 0, edges_cur = 0, win_count = 0, win1_edges = -1;
    bit in_win = 0;

    function automatic logic [7:0] getm(input int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @(negedge spi_cs_n) begin
        bitc = 0; nby = 0; out_sh = '0; edges_cur = 0; in_win = 1;
        cur.delete();
    end

    always @(posedge spi_cs_n) begin
        if (in_win) begin
            in_win = 0;
            win_count++;
            last = cur;
            if (win_count == 1) win1_edges = edges_cur;
        end
    end

    always @(posedge spi_sclk) begin
        if (spi_cs_n === 1'b0) begin
            edges_cur++;
            in_sh = {in_sh[6:0], spi_mosi};
            bitc++;
            if (bitc == 8) begin
                bitc = 0;
                cur.push_back(in_sh);
                case (nby)
                    0: begin opc = in_sh; if (in_sh == 8'h0E) out_sh = mode_code; end
                    1: begin saddr[15:8] = in_sh; if (opc == 8'h01) status = in_sh; end
                    2: begin saddr[7:0] = in_sh; if (opc == 8'h03) out_sh = getm(int'(saddr)); end
                    default: begin
                        if (opc == 8'h02) begin mem[int'(saddr)] = in_sh; saddr = saddr + 16'd1; end
                        else if (opc == 8'h03) begin saddr = saddr + 16'd1; out_sh = getm(int'(saddr)); end
                    end
                endcase
                nby++;
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (spi_cs_n === 1'b0) spi_miso = out_sh[7 - bitc];
    end

    // ---------------- write-data source with per-byte stalls ----------------
    logic [7:0] wq [$];
    int sq [$];
    int stall_ok = 0, stall_bad = 0;
    initial begin
        bit pend;
        pend = 0;
        forever begin
            @(negedge clk);
            if (pend) begin
                wr_valid = 1'b0;
                void'(wq.pop_front());
                void'(sq.pop_front());
                pend = 0;
            end else if (wr_ready && !wr_valid && wq.size() > 0) begin
                if (sq[0] > 0) begin
                    sq[0] = sq[0] - 1;
                    if (!spi_cs_n && !spi_sclk) stall_ok++; else stall_bad++;
                end else begin
                    wr_valid = 1'b1;
                    wr_data  = wq[0];
                end
            end
            if (wr_valid && wr_ready) pend = 1;
        end
    end

    // ---------------- read capture ----------------
    logic [7:0] rq [$];
    always @(negedge clk) if (rd_valid) rq.push_back(rd_data);

    // ---------------- per-clock reference comparisons ----------------
    int hi_run = 0, cyc = 0, last_rise = -1, min_per = 1000;
    logic prev_cs = 1'b1, prev_sclk = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(!(spi_sclk && spi_cs_n), "R11 sclk high with cs high", int'(spi_sclk), 0);
            chk(busy || spi_cs_n, "R10 cs low while not busy", int'(spi_cs_n), 1);
            if (spi_cs_n) hi_run++;
            else begin
                if (prev_cs) chk(hi_run >= 2 * HD, "R11 cs high gap", hi_run, 2 * HD);
                hi_run = 0;
            end
            if (spi_sclk && !prev_sclk) begin
                if (last_rise >= 0 && cyc - last_rise < min_per) min_per = cyc - last_rise;
                last_rise = cyc;
            end
            prev_cs = spi_cs_n;
            prev_sclk = spi_sclk;
        end
    end

    // ---------------- command helpers ----------------
    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [2:0] op, input logic [15:0] a, input int n);
        wait_idle();
        cmd_op = op; cmd_addr = a; cmd_count = CW'(n); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        wait_idle();
    endtask

    task automatic chk_last(input string tag, input int idx, input int exp);
        chk(last.size() > idx && last[idx] == exp[7:0], tag,
            (last.size() > idx) ? int'(last[idx]) : -1, exp);
    endtask

    task automatic size_query(input logic [7:0] code, input int exp);
        mode_code = code;
        send_cmd(3'd6, 16'h0000, 0);
        chk_last("R8 size opcode", 0, 8'h0E);
        chk_last("R8 size dummy", 1, 8'hFF);
        chk(int'(mem_bytes) == exp, "R8 decoded size", int'(mem_bytes), exp);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        int w0;
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R3 reset cs_n", int'(spi_cs_n), 1);
        chk(spi_sclk == 1'b0, "R3 reset sclk", int'(spi_sclk), 0);
        chk(busy == 1'b1, "R3 reset busy", int'(busy), 1);
        chk(mem_bytes == '0, "R8 reset size", int'(mem_bytes), 0);
        rst_n = 1'b1;
        @(negedge clk);
        wait_idle();
        chk(win_count == 2, "R3 boot window count", win_count, 2);
        chk(win1_edges == 0, "R3 boot pulse clock edges", win1_edges, 0);
        chk(last.size() == 2, "R3 config length", last.size(), 2);
        chk_last("R3 config opcode", 0, 8'h01);
        chk_last("R3 config value", 1, 8'h41);

        // R10: op code 7 is ignored
        w0 = win_count;
        cmd_op = 3'd7; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R10 op 7 busy", int'(busy), 0);
        chk(win_count == w0, "R10 op 7 window count", win_count, w0);

        size_query(8'd2, 32768);
        size_query(8'd3, 65536);
        size_query(8'd9, 0);

        // R4 and R1: single write ignores count
        wq.push_back(8'hA5); sq.push_back(0);
        send_cmd(3'd1, 16'h1234, 5);
        chk(last.size() == 4, "R4 single write length", last.size(), 4);
        chk_last("R4 write opcode", 0, 8'h02);
        chk_last("R4 address high", 1, 8'h12);
        chk_last("R4 address low", 2, 8'h34);
        chk_last("R1 data byte order", 3, 8'hA5);
        chk(getm(16'h1234) == 8'hA5, "R4 memory byte", int'(getm(16'h1234)), 8'hA5);

        // R5: single read
        rq.delete();
        send_cmd(3'd3, 16'h1234, 7);
        chk(last.size() == 4, "R5 single read length", last.size(), 4);
        chk_last("R5 read opcode", 0, 8'h03);
        chk_last("R5 dummy byte", 3, 8'h00);
        chk(rq.size() == 1, "R5 strobe count", rq.size(), 1);
        chk(rq.size() > 0 && rq[0] == 8'hA5, "R5 read data", (rq.size() > 0) ? int'(rq[0]) : -1, 8'hA5);

        // R6 and R7: burst write with stalls
        wq.push_back(8'h11); sq.push_back(5);
        wq.push_back(8'h22); sq.push_back(0);
        wq.push_back(8'h33); sq.push_back(3);
        wq.push_back(8'h44); sq.push_back(0);
        send_cmd(3'd2, 16'hFFFE, 4);
        chk(stall_ok == 8, "R7 stall samples hold clock and select", stall_ok, 8);
        chk(stall_bad == 0, "R7 stall violations", stall_bad, 0);
        chk(last.size() == 7, "R6 burst write length", last.size(), 7);
        chk(getm(16'hFFFF) == 8'h22, "R6 burst byte 2", int'(getm(16'hFFFF)), 8'h22);
        chk(getm(0) == 8'h33, "R6 burst byte 3", int'(getm(0)), 8'h33);

        // R5, R6 and R10: burst read with a command poked while busy
        rq.delete();
        w0 = win_count;
        wait_idle();
        cmd_op = 3'd4; cmd_addr = 16'hFFFE; cmd_count = CW'(4); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (10) @(negedge clk);
        cmd_op = 3'd3; cmd_addr = 16'h1234; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_idle();
        repeat (6) @(negedge clk);
        chk(win_count == w0 + 1, "R10 command while busy ignored", win_count, w0 + 1);
        chk(last.size() == 7, "R6 burst read length", last.size(), 7);
        chk(rq.size() == 4, "R5 burst strobes", rq.size(), 4);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] e;
            e = 8'h11 + 8'(i) * 8'h11;
            chk(rq.size() > i && rq[i] == e, "R5 burst read data", (rq.size() > i) ? int'(rq[i]) : -1, int'(e));
        end

        // R9: clear-all over the detected size
        wq.push_back(8'h55); sq.push_back(0);
        send_cmd(3'd1, 16'h0100, 1);
        mem[8192] = 8'h77;
        size_query(8'd0, 8192);
        send_cmd(3'd5, 16'h4444, 3);
        chk(last.size() == 8195, "R9 clear length", last.size(), 8195);
        chk_last("R9 clear opcode", 0, 8'h02);
        chk_last("R9 clear address high", 1, 8'h00);
        chk_last("R9 clear address low", 2, 8'h00);
        chk(getm(16'h0100) == 8'h00, "R9 cleared byte", int'(getm(16'h0100)), 0);
        chk(getm(8192) == 8'h77, "R9 byte past size untouched", int'(getm(8192)), 8'h77);

        chk(min_per == 2 * HD, "R2 sclk period", min_per, 2 * HD);

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule